// File: doc/BRIEF.md
# System Control Flags Peripheral with Pause and Boot-Map Release

This peripheral sits on an APB-style register bus. It drives two control flags and serves two readable values. The first flag, `pause_o`, asks the rest of the system to halt its clock until an interrupt arrives. Software raises it with a write. Either active-low interrupt line, or the reset, drops it again without a clock edge, so the flag can be released while the clock is already stopped. The second flag, `remap_o`, starts low, which selects the boot memory map. One write raises it, and from then on only a reset returns it to the boot map.

The readable values are a small reset-cause register and a fixed identification word. The reset-cause register has its own set and clear locations, so software can change single bits without a read-modify-write sequence. Bit 0 of that register records a power-on reset. Only the reset raises it; software can clear it but never set it. Read data is selected during the setup phase and is held in a register, so the bus output never carries the delay of the selection logic.

Top module: `apb_sysctl`

## Requirements
- R1: While reset is asserted and immediately after it, `pause_o` and `remap_o` are 0, `apb_rdata` is 0, and the reset-cause register reads 0x01.
- R2: A write (select, enable and write all high at a rising edge) of any data to byte offset 0x00 sets `pause_o` at that edge.
- R3: `pause_o` drops to 0 at once, without a clock edge, when `irq_fast_n` or `irq_norm_n` is low. A pause write made while either line is low leaves it at 0. Otherwise a set `pause_o` stays at 1.
- R4: A write of any data to offset 0x30 sets `remap_o`. Once set, it stays set until reset.
- R5: A write to offset 0x44 sets each reset-cause bit 7..1 whose data bit is 1 and leaves every other bit unchanged.
- R6: A write to offset 0x48 clears each reset-cause bit, bit 0 included, whose data bit is 1. Bit 0 never rises except through reset.
- R7: A read of offset 0x10 returns the identification parameter `ID_VALUE` (default all zeros).
- R8: Read data is captured only in the setup phase (select high, enable low, write low). It stays unchanged through the access phase and any later cycles until the next setup phase. Offset 0x40 returns the reset-cause register in bits 7:0, with zeros above.
- R9: Reads of write-only (0x00, 0x30, 0x44, 0x48) or unmapped offsets return 0. Writes to read-only (0x10, 0x40) or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| apb_sel | input | 1 | Peripheral select |
| apb_en | input | 1 | Access-phase enable |
| apb_wr | input | 1 | 1 = write, 0 = read |
| apb_addr | input | ADDR_W (8) | Byte address; bits 1:0 ignored |
| apb_wdata | input | DATA_W (32) | Write data |
| apb_rdata | output | DATA_W (32) | Registered read data |
| irq_fast_n | input | 1 | Active-low fast interrupt, clears pause asynchronously |
| irq_norm_n | input | 1 | Active-low normal interrupt, clears pause asynchronously |
| pause_o | output | 1 | Wait-for-interrupt request |
| remap_o | output | 1 | 0 = boot map, 1 = normal map |

## Verification
Two actions can meet in the same cycle: a pause write, which sets the flag at a clock edge, and an interrupt, which clears it with no edge at all. The bench holds an interrupt line low across the edge at which a pause write lands. The interrupt must win, so `pause_o` has to stay 0 after the line is released. The bench also pulls an interrupt low between edges while pause is set, and checks one time step later, before any edge, that the flag has already dropped. Random sequences of writes, reads and interrupt pulses mix both events, and a bench model decides the expected flag after each one.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int unsigned OFF_PAUSE   = 32'h00;
   localparam int unsigned OFF_IDENT   = 32'h10;
   localparam int unsigned OFF_MAPREL  = 32'h30;
   localparam int unsigned OFF_CAUSE   = 32'h40;
   localparam int unsigned OFF_CSET    = 32'h44;
   localparam int unsigned OFF_CCLR    = 32'h48;
   localparam int unsigned MIN_ADDR_W  = 7;

   typedef struct packed {
      logic pause;
      logic ident;
      logic maprel;
      logic cause;
      logic cset;
      logic cclr;
   } sysctl_hit_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output sysctl_hit_t       hit
);

   localparam logic [ADDR_W-1:0] A_PAUSE  = ADDR_W'(OFF_PAUSE);
   localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFF_IDENT);
   localparam logic [ADDR_W-1:0] A_MAPREL = ADDR_W'(OFF_MAPREL);
   localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFF_CAUSE);
   localparam logic [ADDR_W-1:0] A_CSET   = ADDR_W'(OFF_CSET);
   localparam logic [ADDR_W-1:0] A_CCLR   = ADDR_W'(OFF_CCLR);

   logic [ADDR_W-3:0] word;
   assign word = addr[ADDR_W-1:2];

   always_comb begin
      hit        = '0;
      hit.pause  = (word == A_PAUSE[ADDR_W-1:2]);
      hit.ident  = (word == A_IDENT[ADDR_W-1:2]);
      hit.maprel = (word == A_MAPREL[ADDR_W-1:2]);
      hit.cause  = (word == A_CAUSE[ADDR_W-1:2]);
      hit.cset   = (word == A_CSET[ADDR_W-1:2]);
      hit.cclr   = (word == A_CCLR[ADDR_W-1:2]);
   end

   always_comb begin
      assert_onehot_hit_R9: assert ($onehot0(hit))
         else $error("more than one register decoded");
   end

endmodule

// File: rtl/sysctl_pause.sv
module sysctl_pause (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_fast_n,
   input  logic irq_norm_n,
   input  logic set_req,
   output logic pause
);

   logic release_n;
   logic pause_q;

   assign release_n = rst_n & irq_fast_n & irq_norm_n;

   always_ff @(posedge clk or negedge release_n) begin
      if (!release_n) pause_q <= 1'b0;
      else if (set_req) pause_q <= 1'b1;
   end

   assign pause = pause_q;

   assert_pause_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req && irq_fast_n && irq_norm_n) |=> (pause_q || !irq_fast_n || !irq_norm_n))
      else $error("pause write did not raise the flag");

   assert_pause_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_fast_n || !irq_norm_n) |-> !pause_q)
      else $error("pause high while an interrupt is asserted");

   assert_pause_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pause_q |=> (pause_q || !irq_fast_n || !irq_norm_n || !$past(irq_fast_n)
                   || !$past(irq_norm_n)))
      else $error("pause dropped without an interrupt");

endmodule

// File: rtl/sysctl_cause.sv
module sysctl_cause #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [STAT_W-1:0] wbits,
   output logic [STAT_W-1:0] cause
);

   localparam logic [STAT_W-1:0] SW_MASK = {{(STAT_W-1){1'b1}}, 1'b0};

   logic do_set;
   logic do_clr;

   assign do_set = set_en & ~clr_en;
   assign do_clr = clr_en & ~set_en;

   for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bit
      logic bit_q;
      if (gi == 0) begin : g_por
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b1;
            else if (do_clr && wbits[gi]) bit_q <= 1'b0;
         end
      end else begin : g_sw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else if (do_set && wbits[gi]) bit_q <= 1'b1;
            else if (do_clr && wbits[gi]) bit_q <= 1'b0;
         end
      end
      assign cause[gi] = bit_q;
   end

   assert_cause_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      do_set |=> (cause == ($past(cause) | ($past(wbits) & SW_MASK))))
      else $error("set location misbehaved");

   assert_cause_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      do_clr |=> (cause == ($past(cause) & ~$past(wbits))))
      else $error("clear location misbehaved");

   assert_por_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cause[0] |=> !cause[0])
      else $error("power-on bit rose outside reset");

   assert_cause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_en || clr_en) |=> $stable(cause))
      else $error("cause register changed without a write");

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                STAT_W   = 8,
   parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  sysctl_hit_t       hit,
   input  logic [STAT_W-1:0] cause,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] rd_q;
   logic [DATA_W-1:0] cause_ext;

   if (STAT_W == DATA_W) begin : g_full
      assign cause_ext = cause;
   end else begin : g_pad
      assign cause_ext = {{(DATA_W-STAT_W){1'b0}}, cause};
   end

   always_comb begin
      rd_next = '0;
      if (hit.ident) rd_next = ID_VALUE;
      if (hit.cause) rd_next = cause_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else if (capture) rd_q <= rd_next;
   end

   assign rdata = rd_q;

   assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(rd_q))
      else $error("read data changed outside setup phase");

   assert_rdata_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !hit.ident && !hit.cause) |=> (rd_q == '0))
      else $error("non-readable location returned data");

endmodule

// File: rtl/apb_sysctl.sv
module apb_sysctl
   import sysctl_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 32,
   parameter int                STAT_W   = 8,
   parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apb_sel,
   input  logic              apb_en,
   input  logic              apb_wr,
   input  logic [ADDR_W-1:0] apb_addr,
   input  logic [DATA_W-1:0] apb_wdata,
   output logic [DATA_W-1:0] apb_rdata,
   input  logic              irq_fast_n,
   input  logic              irq_norm_n,
   output logic              pause_o,
   output logic              remap_o
);

   if (ADDR_W < int'(MIN_ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (STAT_W < 1 || STAT_W > DATA_W) begin : g_chk_stat
      $error("STAT_W must lie between 1 and DATA_W");
   end

   sysctl_hit_t hit;
   logic        wr_cyc;
   logic        rd_setup;
   logic        remap_q;

   assign wr_cyc   = apb_sel & apb_en & apb_wr;
   assign rd_setup = apb_sel & ~apb_en & ~apb_wr;

   sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (apb_addr),
      .hit  (hit)
   );

   sysctl_pause u_pause (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_fast_n (irq_fast_n),
      .irq_norm_n (irq_norm_n),
      .set_req    (wr_cyc & hit.pause),
      .pause      (pause_o)
   );

   logic [STAT_W-1:0] cause;

   sysctl_cause #(.STAT_W(STAT_W)) u_cause (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_cyc & hit.cset),
      .clr_en (wr_cyc & hit.cclr),
      .wbits  (apb_wdata[STAT_W-1:0]),
      .cause  (cause)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) remap_q <= 1'b0;
      else if (wr_cyc && hit.maprel) remap_q <= 1'b1;
   end

   assign remap_o = remap_q;

   sysctl_rdmux #(
      .DATA_W   (DATA_W),
      .STAT_W   (STAT_W),
      .ID_VALUE (ID_VALUE)
   ) u_rdmux (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (rd_setup),
      .hit     (hit),
      .cause   (cause),
      .rdata   (apb_rdata)
   );

   assert_remap_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      remap_q |=> remap_q)
      else $error("remap flag fell without reset");

   assert_remap_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!remap_q && !(apb_sel && apb_en && apb_wr && hit.maprel)) |=> !remap_q)
      else $error("remap flag rose without its write");

endmodule

// File: tb/apb_sysctl_bench.sv
module apb_sysctl_bench;

   localparam logic [31:0] IDV = 32'h5A17_00C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, en = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ifq_n = 1'b1, inq_n = 1'b1;
   logic        pause, remap;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   logic       m_pause, m_remap;
   logic [7:0] m_cause;

   always #4 clk = ~clk;

   apb_sysctl #(.ID_VALUE(IDV)) u_apb_sysctl (
      .clk(clk), .rst_n(rst_n), .apb_sel(sel), .apb_en(en), .apb_wr(wr),
      .apb_addr(addr), .apb_wdata(wdata), .apb_rdata(rdata),
      .irq_fast_n(ifq_n), .irq_norm_n(inq_n), .pause_o(pause), .remap_o(remap)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case ({a[7:2], 2'b00})
         8'h10:   return IDV;
         8'h40:   return {24'h0, m_cause};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string read_tag(input logic [7:0] a);
      case ({a[7:2], 2'b00})
         8'h10:   return "R7";
         8'h40:   return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [31:0] d);
      case ({a[7:2], 2'b00})
         8'h00: if (ifq_n && inq_n) m_pause = 1'b1;
         8'h30: m_remap = 1'b1;
         8'h44: m_cause = m_cause | (d[7:0] & 8'hFE);
         8'h48: m_cause = m_cause & ~d[7:0];
         default: ;
      endcase
   endtask

   task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); sel = 1; wr = 1; en = 0; addr = a; wdata = d;
      @(negedge clk); en = 1;
      @(negedge clk); sel = 0; en = 0; wr = 0;
      model_write(a, d);
   endtask

   task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); sel = 1; wr = 0; en = 0; addr = a;
      @(negedge clk); en = 1;
      #1 d = rdata;
      @(negedge clk); sel = 0; en = 0;
   endtask

   task automatic read_check(input logic [7:0] a);
      logic [31:0] d;
      apb_read(a, d);
      check(read_tag(a), d, exp_read(a));
   endtask

   task automatic flags_check(input string tag);
      check({tag, " R2/R3 pause"}, {31'h0, pause}, {31'h0, m_pause});
      check({tag, " R4 remap"}, {31'h0, remap}, {31'h0, m_remap});
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      #1;
      m_pause = 0; m_remap = 0; m_cause = 8'h01;
      check("R1 pause in reset", {31'h0, pause}, 32'h0);
      check("R1 remap in reset", {31'h0, remap}, 32'h0);
      check("R1 rdata in reset", rdata, 32'h0);
      @(negedge clk); @(negedge clk); rst_n = 1;
   endtask

   task automatic irq_pulse(input bit which);
      @(negedge clk);
      if (which) ifq_n = 0; else inq_n = 0;
      #1 check("R3 async clear", {31'h0, pause}, 32'h0);
      m_pause = 0;
      @(negedge clk);
      ifq_n = 1; inq_n = 1;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin : main
      logic [31:0] d, held;
      logic [7:0]  pool [10] = '{8'h00, 8'h04, 8'h10, 8'h20, 8'h30,
                                 8'h40, 8'h44, 8'h48, 8'h4C, 8'hFC};
      void'($urandom(32'd2024));
      m_pause = 0; m_remap = 0; m_cause = 8'h01;
      #1;
      check("R1 pause before edge", {31'h0, pause}, 32'h0);
      check("R1 remap before edge", {31'h0, remap}, 32'h0);
      check("R1 rdata before edge", rdata, 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 cause after reset
      read_check(8'h40);
      // R7 identification
      read_check(8'h10);
      // R9 write-only and unmapped reads
      read_check(8'h00); read_check(8'h30); read_check(8'h44);
      read_check(8'h48); read_check(8'h20);
      // R9 writes to read-only/unmapped
      apb_write(8'h10, 32'hFFFF_FFFF);
      apb_write(8'h40, 32'hFFFF_FFFF);
      apb_write(8'h24, 32'hFFFF_FFFF);
      read_check(8'h10); read_check(8'h40);
      flags_check("R9 after dead writes");
      // R5: bit 0 cleared, then set location cannot restore it (R6)
      apb_write(8'h48, 32'h0000_0001);
      read_check(8'h40);
      apb_write(8'h44, 32'hFFFF_FFFF);
      read_check(8'h40);
      check("R6 bit0 stays low", {31'h0, m_cause[0]}, 32'h0);
      apb_write(8'h48, 32'h0000_0050);
      read_check(8'h40);
      // R8: read data held through unrelated writes
      apb_read(8'h40, held);
      apb_write(8'h48, 32'h0000_00FF);
      #1 check("R8 rdata held", rdata, held);
      read_check(8'h40);
      // R2 pause set, R3 hold, R3 async clear by each line
      apb_write(8'h00, 32'h0);
      flags_check("R2 set");
      apb_write(8'h44, 32'h0000_0002);
      flags_check("R3 hold");
      irq_pulse(1'b1);
      flags_check("R3 fast cleared");
      apb_write(8'h00, 32'h1234);
      irq_pulse(1'b0);
      flags_check("R3 norm cleared");
      // R3 collision: pause write while interrupt held low
      @(negedge clk); ifq_n = 0;
      apb_write(8'h00, 32'hDEAD);
      @(negedge clk); ifq_n = 1;
      #1 check("R3 write during irq", {31'h0, pause}, 32'h0);
      // R4 remap sticky
      apb_write(8'h30, 32'h0);
      flags_check("R4 set");
      irq_pulse(1'b0);
      apb_write(8'h48, 32'hFFFF_FFFF);
      flags_check("R4 sticky");
      // random phase
      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 9);
         logic [7:0] a = pool[$urandom_range(0, 9)];
         if (op < 5) apb_write(a, $urandom());
         else if (op < 9) read_check(a);
         else irq_pulse(1'($urandom_range(0, 1)));
         flags_check("random");
         if (i == 200) begin
            do_reset();
            read_check(8'h40);
            flags_check("R1 after mid reset");
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule